// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address, as a processor running in real-address mode does. The segment value is moved up by four bit positions, a zero nibble fills the low end, and the offset is added. Any carry beyond bit 19 is dropped, so the 1,048,576-byte space wraps around. Each address names one byte.

Four segment registers are held inside the block: extra, code, stack and data. Each request carries an access kind, and the kind chooses the default segment. Instruction fetches use the code segment. Stack-top and frame (base-pointer) accesses use the stack segment. Plain data and source-index accesses use the data segment. String-destination accesses use the extra segment. A request may carry a segment override. The override is honoured only for data, source-index and frame accesses.

The result is registered and appears one clock after the request, together with a valid strobe and a region flag. The flag separates the low RAM area from the high ROM area. The segment registers are loaded through a select-and-data write port.

Top module: `seg_addr_gen`

## Requirements
- R1: The output address is (segment × 16 + offset) modulo 2^20. A carry out of bit 19 is discarded. For example, segment 08F1h with offset 0100h gives 09010h, and segment FFFFh with offset 0010h gives 00000h.
- R2: Access kind code 0 (instruction fetch) always uses the code segment. The override input has no effect on it.
- R3: Access kind code 1 (stack top) always uses the stack segment. The override input has no effect on it.
- R4: Access kind code 2 (frame access) uses the stack segment when no override is given.
- R5: Access kind code 3 (data) and code 4 (source index) use the data segment when no override is given.
- R6: Access kind code 5 (string destination) always uses the extra segment. The override input has no effect on it.
- R7: For kind codes 2, 3 and 4, `ovr_valid` high makes the request use the segment named by `ovr_sel`. The encoding is 0 = extra, 1 = code, 2 = stack, 3 = data.
- R8: `out_rom` is 1 when the output address is C0000h or above. It is 0 for addresses 00000h to BFFFFh.
- R9: `out_valid` rises in the cycle after a request and only then. `out_addr` and `out_rom` update only on a request and otherwise hold their values.
- R10: After reset, all segment registers read as zero. `out_valid`, `out_addr` and `out_rom` are also zero.
- R11: A write with `wr_en` loads `wr_data` into the segment named by `wr_sel`, using the same encoding as R7. The new value is used by requests in later cycles. A request in the same cycle as the write still sees the old value.
- R12: The unused kind codes 6 and 7 behave like a data access (code 3), including the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write (0 extra, 1 code, 2 stack, 3 data) |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 3 | Access kind code |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 20 | Physical byte address |
| out_rom | output | 1 | 1 = ROM region, 0 = RAM region |

## Verification
The bench builds the block with its default parameters: 16-bit segment and offset, a 4-bit shift and the ROM boundary at C0000h. With these values, full-width segment values such as FFFFh reach the wrap past FFFFFh and the last byte of the space. The segment values BFFFh and C000h land exactly on both sides of the region boundary. Four distinct segment values make every default and override choice visible in the address. Writes issued in the same cycle as a request test the old-value rule.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
// Package: shared codes for the segmented address generator.
// Assumes a 3-bit access kind and a 2-bit segment index.
package seg_addr_pkg;
    localparam int KIND_W = 3;
    localparam int SIDX_W = 2;

    // access kind codes seen on req_kind
    localparam logic [KIND_W-1:0] KIND_FETCH = 3'd0;
    localparam logic [KIND_W-1:0] KIND_STACK = 3'd1;
    localparam logic [KIND_W-1:0] KIND_FRAME = 3'd2;
    localparam logic [KIND_W-1:0] KIND_DATA  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_SRC   = 3'd4;
    localparam logic [KIND_W-1:0] KIND_DST   = 3'd5;

    // segment register indices (write select and override share them)
    localparam logic [SIDX_W-1:0] SEG_EXTRA = 2'd0;
    localparam logic [SIDX_W-1:0] SEG_CODE  = 2'd1;
    localparam logic [SIDX_W-1:0] SEG_STACK = 2'd2;
    localparam logic [SIDX_W-1:0] SEG_DATA  = 2'd3;
endpackage

// File: rtl/seg_bank.sv
`timescale 1ns/1ps
// Module: seg_bank
// Holds NUM_SEG segment registers with one write port and one
// combinational read port. A write lands at the clock edge, so a read
// in the same cycle returns the old value. Reset clears every register.
module seg_bank #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 4,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SEG_W-1:0] rd_val
);
    logic [SEG_W-1:0] seg_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        // one register per segment, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                seg_q[g] <= wr_val;
        end

        p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_en) && ($past(wr_idx) == IDX_W'(g)))
                |-> (seg_q[g] == $past(wr_val)))
            else $error("segment write lost (R11)");
    end

    // read mux for the selected segment
    always_comb rd_val = seg_q[rd_idx];
endmodule

// File: rtl/seg_choose.sv
`timescale 1ns/1ps
// Module: seg_choose
// Picks the segment register index for an access from its kind.
// An override is honoured only for data, source-index and frame
// accesses. Unused kind codes are treated as data accesses.
module seg_choose
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              ovr_valid,
    input  logic [SIDX_W-1:0] ovr_sel,
    output logic [SIDX_W-1:0] seg_idx
);
    logic [SIDX_W-1:0] dflt_idx;
    logic              ovr_ok;

    // default segment and override eligibility per kind
    always_comb begin
        unique case (kind)
            KIND_FETCH: begin dflt_idx = SEG_CODE;  ovr_ok = 1'b0; end
            KIND_STACK: begin dflt_idx = SEG_STACK; ovr_ok = 1'b0; end
            KIND_FRAME: begin dflt_idx = SEG_STACK; ovr_ok = 1'b1; end
            KIND_DST:   begin dflt_idx = SEG_EXTRA; ovr_ok = 1'b0; end
            default:    begin dflt_idx = SEG_DATA;  ovr_ok = 1'b1; end
        endcase
    end

    // apply the override where allowed
    always_comb seg_idx = (ovr_ok && ovr_valid) ? ovr_sel : dflt_idx;
endmodule

// File: rtl/phys_adder.sv
`timescale 1ns/1ps
// Module: phys_adder
// Shifts the segment left by SHIFT bits, adds the zero-extended offset
// and keeps PA_W bits (the carry out is dropped). It also flags results
// at or above ROM_BASE. Assumes PA_W = SEG_W + SHIFT and PA_W > OFF_W.
module phys_adder #(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int ROM_BASE = 32'hC0000,
    localparam int PA_W    = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  paddr,
    output logic             is_rom
);
    localparam logic [PA_W-1:0] ROM_LIM = PA_W'(ROM_BASE);

    logic [PA_W-1:0] seg_ext;
    logic [PA_W-1:0] off_ext;

    // align both operands to the physical width
    always_comb begin
        seg_ext = {seg, {SHIFT{1'b0}}};
        off_ext = {{(PA_W-OFF_W){1'b0}}, off};
    end

    // modular sum and region decode
    always_comb begin
        paddr  = seg_ext + off_ext;
        is_rom = (paddr >= ROM_LIM);
    end
endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
// Module: seg_addr_gen (top)
// Segmented physical address generator. It holds four segment
// registers and picks one by access kind, with an optional override.
// It forms segment*16 + offset modulo 2^PA_W and registers the address
// and region flag one clock after the request.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int ROM_BASE = 32'hC0000,
    localparam int PA_W    = SEG_W + SHIFT,
    localparam int NUM_SEG = 1 << SIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SIDX_W-1:0] wr_sel,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [SIDX_W-1:0] ovr_sel,
    output logic              out_valid,
    output logic [PA_W-1:0]   out_addr,
    output logic              out_rom
);
    localparam logic [PA_W-1:0] ROM_LIM = PA_W'(ROM_BASE);

    logic [SIDX_W-1:0] sel_idx;
    logic [SEG_W-1:0]  sel_seg;
    logic [PA_W-1:0]   sum_addr;
    logic              sum_rom;

    seg_choose u_choose (
        .kind      (req_kind),
        .ovr_valid (ovr_valid),
        .ovr_sel   (ovr_sel),
        .seg_idx   (sel_idx)
    );

    seg_bank #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_sel),
        .wr_val (wr_data),
        .rd_idx (sel_idx),
        .rd_val (sel_seg)
    );

    phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT),
                 .ROM_BASE(ROM_BASE)) u_add (
        .seg    (sel_seg),
        .off    (req_offset),
        .paddr  (sum_addr),
        .is_rom (sum_rom)
    );

    // output register: strobe every cycle, result only on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_rom   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr <= sum_addr;
                out_rom  <= sum_rom;
            end
        end
    end

    p_fetch_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_FETCH) |-> (sel_idx == SEG_CODE))
        else $error("fetch not on code segment (R2)");

    p_stack_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_STACK) |-> (sel_idx == SEG_STACK))
        else $error("stack access not on stack segment (R3)");

    p_dst_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == KIND_DST) |-> (sel_idx == SEG_EXTRA))
        else $error("destination not on extra segment (R6)");

    p_region_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rom == (out_addr >= ROM_LIM)))
        else $error("region flag disagrees with address (R8)");

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(req_valid)))
        else $error("valid strobe latency (R9)");

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid)) |-> ($stable(out_addr) && $stable(out_rom)))
        else $error("result changed without request (R9)");
endmodule

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic        out_rom;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] mseg [4];

    always #5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_kind(req_kind),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .out_addr(out_addr), .out_rom(out_rom)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    // expected segment index per requirement R2..R7, R12
    function automatic logic [1:0] pick(input logic [2:0] k, input logic ov, input logic [1:0] os);
        case (k)
            3'd0: return 2'd1;
            3'd1: return 2'd2;
            3'd5: return 2'd0;
            3'd2: return ov ? os : 2'd2;
            default: return ov ? os : 2'd3;
        endcase
    endfunction

    task automatic seg_write(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mseg[s] = v;
    endtask

    // issue one request, sample the registered result one clock later
    task automatic request(input string tag, input logic [2:0] k, input logic [15:0] o,
                           input logic ov, input logic [1:0] os);
        logic [19:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_offset = o; ovr_valid = ov; ovr_sel = os;
        e = phys(mseg[pick(k, ov, os)], o);
        @(negedge clk);
        req_valid = 1'b0; ovr_valid = 1'b0;
        chk({tag, " valid R9"}, {19'd0, out_valid}, 20'd1);
        chk({tag, " addr"}, out_addr, e);
        chk({tag, " region R8"}, {19'd0, out_rom}, {19'd0, e >= 20'hC0000});
    endtask

    task automatic t_reset;
        chk("R10 valid", {19'd0, out_valid}, 20'd0);
        chk("R10 addr", out_addr, 20'd0);
        chk("R10 rom", {19'd0, out_rom}, 20'd0);
        for (int i = 0; i < 4; i++) mseg[i] = 16'h0;
        request("R10 zero segment", 3'd3, 16'h1234, 1'b0, 2'd0);
    endtask

    task automatic t_example;
        seg_write(2'd3, 16'h08F1);
        request("R1 example 08F1:0100", 3'd3, 16'h0100, 1'b0, 2'd0);
        chk("R1 example literal", out_addr, 20'h09010);
    endtask

    task automatic t_defaults;
        seg_write(2'd0, 16'h4000);
        seg_write(2'd1, 16'h1000);
        seg_write(2'd2, 16'h3000);
        seg_write(2'd3, 16'h2000);
        request("R2 fetch", 3'd0, 16'h0010, 1'b0, 2'd0);
        request("R3 stack", 3'd1, 16'h0020, 1'b0, 2'd0);
        request("R4 frame", 3'd2, 16'h0030, 1'b0, 2'd0);
        request("R5 data", 3'd3, 16'h0040, 1'b0, 2'd0);
        request("R5 source", 3'd4, 16'h0050, 1'b0, 2'd0);
        request("R6 destination", 3'd5, 16'h0060, 1'b0, 2'd0);
    endtask

    task automatic t_override;
        request("R7 data to extra", 3'd3, 16'h0001, 1'b1, 2'd0);
        request("R7 source to code", 3'd4, 16'h0002, 1'b1, 2'd1);
        request("R7 frame to data", 3'd2, 16'h0003, 1'b1, 2'd3);
        request("R7 data to stack", 3'd3, 16'h0004, 1'b1, 2'd2);
        request("R2 fetch ignores override", 3'd0, 16'h0005, 1'b1, 2'd3);
        chk("R2 fetch literal", out_addr, 20'h10005);
        request("R3 stack ignores override", 3'd1, 16'h0006, 1'b1, 2'd0);
        chk("R3 stack literal", out_addr, 20'h30006);
        request("R6 destination ignores override", 3'd5, 16'h0007, 1'b1, 2'd1);
        chk("R6 destination literal", out_addr, 20'h40007);
    endtask

    task automatic t_unused_kinds;
        request("R12 kind 6", 3'd6, 16'h0100, 1'b0, 2'd0);
        chk("R12 kind 6 literal", out_addr, 20'h20100);
        request("R12 kind 7 override", 3'd7, 16'h0100, 1'b1, 2'd1);
        chk("R12 kind 7 literal", out_addr, 20'h10100);
    endtask

    task automatic t_wrap_region;
        seg_write(2'd3, 16'hFFFF);
        request("R1 wrap FFFF:0010", 3'd3, 16'h0010, 1'b0, 2'd0);
        chk("R1 wrap literal", out_addr, 20'h00000);
        request("R1 wrap FFFF:FFFF", 3'd3, 16'hFFFF, 1'b0, 2'd0);
        request("R8 top byte", 3'd3, 16'h000F, 1'b0, 2'd0);
        chk("R8 top rom", {19'd0, out_rom}, 20'd1);
        seg_write(2'd3, 16'hBFFF);
        request("R8 last RAM byte", 3'd3, 16'h000F, 1'b0, 2'd0);
        chk("R8 ram flag", {19'd0, out_rom}, 20'd0);
        seg_write(2'd3, 16'hC000);
        request("R8 first ROM byte", 3'd3, 16'h0000, 1'b0, 2'd0);
        chk("R8 rom flag", {19'd0, out_rom}, 20'd1);
    endtask

    task automatic t_idle_hold;
        logic [19:0] prev;
        prev = out_addr;
        @(negedge clk);
        req_offset = 16'h7777;
        req_kind = 3'd0;
        @(negedge clk);
        chk("R9 idle valid low", {19'd0, out_valid}, 20'd0);
        chk("R9 idle addr hold", out_addr, prev);
        chk("R9 idle rom hold", {19'd0, out_rom}, 20'd1);
    endtask

    task automatic t_same_cycle_write;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h5000;
        req_valid = 1'b1; req_kind = 3'd0; req_offset = 16'h0008; ovr_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R11 same-cycle old value", out_addr, 20'h10008);
        mseg[1] = 16'h5000;
        request("R11 new value later", 3'd0, 16'h0008, 1'b0, 2'd0);
        chk("R11 new literal", out_addr, 20'h50008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_defaults();
        t_override();
        t_unused_kinds();
        t_wrap_region();
        t_idle_hold();
        t_same_cycle_write();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule